// File: doc/BRIEF.md
# Vectored Interrupt and Hold-Release Controller

This block gathers five event sources for a small processor core: two divider overflow pulses, two timer underflow pulses, and a change detector that watches a 4-pin input port. Each source sets its own bit in an 8-bit event flag register. Each bit is then gated by a per-source interrupt-enable mask and a per-source hold-release mask. The core receives an interrupt request together with a fixed-priority vector address. When it takes the interrupt, it pulses an acknowledge. That pulse clears only the winning flag and closes a global gate, and the gate stays closed until software opens it again.

The block also tracks a low-power hold state. A hold-release condition register mirrors every flag bit whose hold-release enable is set. While any of its bits is 1, a hold request is refused. Once in hold, a release condition or an unmasked pending interrupt raises a wake indication, and the hold state ends on the next edge. The core's pipeline and its return-address stack are outside this block.

Top module: `irq_hold_ctrl`

## Requirements
- R1: A 1-cycle source pulse sets its event flag bit in the cycle after the sampling edge. The bit positions are divider0 = bit 0, timer0 = bit 1, port change = bit 2, divider1 = bit 4 and timer1 = bit 7. Bits 3, 5 and 6 always read 0.
- R2: A change of level on a port pin whose port-enable bit is 1 sets flag bit 2 one edge later. A change on a pin whose port-enable bit is 0 leaves the flags unchanged.
- R3: `irq_o` is 1 when the global gate is open and at least one flag bit has its interrupt-enable bit set. The port source (bit 2) counts only while at least one port-enable bit is 1.
- R4: While `irq_o` is 1, `vec_o` equals 4 × (bit index + 1) of the lowest-numbered requesting bit: 004h, 008h, 00Ch, 014h and 020h for bits 0, 1, 2, 4 and 7. Lower bit numbers have higher priority. `vec_o` is 0 while `irq_o` is 0.
- R5: An acknowledge while `irq_o` is 1 clears only the winning flag bit and closes the gate. A new event on that same bit in the same cycle keeps the bit set. An enable command or an interrupt-enable write opens the gate again.
- R6: A disable command closes the gate and leaves every mask unchanged. If disable and enable arrive in the same cycle, disable wins.
- R7: A flag-clear write clears exactly the bits written as 1. An event arriving in the same cycle on a cleared bit keeps that bit set.
- R8: Each hold-release condition bit equals its event flag bit AND its hold-release enable bit. It drops in the same cycle that either of those bits is cleared.
- R9: A hold request sets `hold_o` on the next edge only if all hold-release condition bits are 0. Otherwise the request has no effect.
- R10: While `hold_o` is 1, any hold-release condition bit, or `irq_o` being 1, raises `hold_wake_o` in that same cycle, and `hold_o` falls on the next edge.
- R11: Reset clears the flags, both enable masks, the port enables, the release conditions, the gate and the hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| div0_ovf_i | input | 1 | Divider0 overflow pulse |
| tmr0_unf_i | input | 1 | Timer0 underflow pulse |
| div1_ovf_i | input | 1 | Divider1 overflow pulse |
| tmr1_unf_i | input | 1 | Timer1 underflow pulse |
| port_pins_i | input | 4 | Watched input port levels |
| ien_we_i | input | 1 | Interrupt-enable mask write strobe |
| ien_wdata_i | input | 8 | Interrupt-enable mask data |
| hen_we_i | input | 1 | Hold-release enable mask write strobe |
| hen_wdata_i | input | 8 | Hold-release enable mask data |
| pen_we_i | input | 1 | Port-enable write strobe |
| pen_wdata_i | input | 4 | Port-enable data |
| evf_clr_we_i | input | 1 | Flag clear strobe |
| evf_clr_mask_i | input | 8 | Flag bits to clear |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| int_en_cmd_i | input | 1 | Open the global gate |
| int_dis_cmd_i | input | 1 | Close the global gate |
| hold_req_i | input | 1 | Request to enter hold |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 11 | Vector address |
| hold_o | output | 1 | Hold state |
| hold_wake_o | output | 1 | Hold is being released this cycle |
| evf_o | output | 8 | Event flags |
| hcf_o | output | 8 | Hold-release conditions |

## Verification
Every state element is a single register, and the outputs are combinational functions of those registers. A stimulus applied before an edge therefore shows up on `evf_o`, `hcf_o`, `irq_o`, `vec_o` and `hold_wake_o` one edge later, and `hold_o` follows the wake indication by one further edge. The driver changes inputs just after a falling edge and steps exactly one rising edge. It then queues the expected values. The monitor compares them 2 ns after that same falling edge, so each item is checked in the one cycle in which it is due.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
    localparam int EVW  = 8;
    localparam int NPIN = 4;

    localparam int B_DIV0 = 0;
    localparam int B_TMR0 = 1;
    localparam int B_PORT = 2;
    localparam int B_DIV1 = 4;
    localparam int B_TMR1 = 7;

    localparam logic [EVW-1:0] SRC_MASK =
        (EVW'(1) << B_DIV0) | (EVW'(1) << B_TMR0) | (EVW'(1) << B_PORT) |
        (EVW'(1) << B_DIV1) | (EVW'(1) << B_TMR1);

    typedef struct packed {
        logic [EVW-1:0]  evf;
        logic [EVW-1:0]  ien;
        logic [EVW-1:0]  hen;
        logic [EVW-1:0]  hcf;
        logic [NPIN-1:0] pen;
        logic            gate;
        logic            hold;
    } ctl_state_t;
endpackage

// File: rtl/irqh_pin_watch.sv
module irqh_pin_watch #(
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins_i,
    input  logic [NPIN-1:0] pen_i,
    output logic            chg_o
);
    logic [NPIN-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = pins_i;
        chg_o  = |((pins_i ^ prev_q) & pen_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irqh_prio_enc.sv
module irqh_prio_enc #(
    parameter int EVW      = 8,
    parameter int VECW     = 11,
    parameter int VEC_STEP = 4
) (
    input  logic [EVW-1:0]  req_i,
    output logic            any_o,
    output logic [EVW-1:0]  win_o,
    output logic [VECW-1:0] vec_o
);
    logic [EVW-1:0] seen;

    assign seen[0] = 1'b0;
    for (genvar g = 1; g < EVW; g++) begin : g_seen
        assign seen[g] = seen[g-1] | req_i[g-1];
    end

    assign win_o = req_i & ~seen;
    assign any_o = |req_i;

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < EVW; i++) begin
            if (win_o[i]) vec_o = VECW'((i + 1) * VEC_STEP);
        end
    end
endmodule

// File: rtl/irq_hold_ctrl.sv
module irq_hold_ctrl
    import irqh_pkg::*;
#(
    parameter int VECW     = 11,
    parameter int VEC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            div0_ovf_i,
    input  logic            tmr0_unf_i,
    input  logic            div1_ovf_i,
    input  logic            tmr1_unf_i,
    input  logic [NPIN-1:0] port_pins_i,
    input  logic            ien_we_i,
    input  logic [EVW-1:0]  ien_wdata_i,
    input  logic            hen_we_i,
    input  logic [EVW-1:0]  hen_wdata_i,
    input  logic            pen_we_i,
    input  logic [NPIN-1:0] pen_wdata_i,
    input  logic            evf_clr_we_i,
    input  logic [EVW-1:0]  evf_clr_mask_i,
    input  logic            ack_i,
    input  logic            int_en_cmd_i,
    input  logic            int_dis_cmd_i,
    input  logic            hold_req_i,
    output logic            irq_o,
    output logic [VECW-1:0] vec_o,
    output logic            hold_o,
    output logic            hold_wake_o,
    output logic [EVW-1:0]  evf_o,
    output logic [EVW-1:0]  hcf_o
);
    ctl_state_t s_q, s_d;

    logic           port_chg;
    logic [EVW-1:0] pend;
    logic [EVW-1:0] win;
    logic [VECW-1:0] enc_vec;
    logic           pend_any;

    irqh_pin_watch #(.NPIN(NPIN)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (port_pins_i),
        .pen_i  (s_q.pen),
        .chg_o  (port_chg)
    );

    // Port source needs at least one pin enabled to request.
    always_comb begin
        pend = s_q.evf & s_q.ien;
        if (s_q.pen == '0) pend[B_PORT] = 1'b0;
    end

    irqh_prio_enc #(.EVW(EVW), .VECW(VECW), .VEC_STEP(VEC_STEP)) u_prio (
        .req_i (pend),
        .any_o (pend_any),
        .win_o (win),
        .vec_o (enc_vec)
    );

    logic           ack_take;
    logic [EVW-1:0] ev_set;
    logic [EVW-1:0] ev_clr;

    always_comb begin
        irq_o       = s_q.gate & pend_any;
        vec_o       = irq_o ? enc_vec : '0;
        ack_take    = ack_i & irq_o;
        hold_wake_o = s_q.hold & ((|s_q.hcf) | irq_o);

        ev_set         = '0;
        ev_set[B_DIV0] = div0_ovf_i;
        ev_set[B_TMR0] = tmr0_unf_i;
        ev_set[B_PORT] = port_chg;
        ev_set[B_DIV1] = div1_ovf_i;
        ev_set[B_TMR1] = tmr1_unf_i;

        ev_clr = '0;
        if (evf_clr_we_i) ev_clr = ev_clr | evf_clr_mask_i;
        if (ack_take)     ev_clr = ev_clr | win;

        s_d     = s_q;
        s_d.evf = ((s_q.evf & ~ev_clr) | ev_set) & SRC_MASK;

        if (ien_we_i) s_d.ien = ien_wdata_i & SRC_MASK;
        if (hen_we_i) s_d.hen = hen_wdata_i & SRC_MASK;
        if (pen_we_i) s_d.pen = pen_wdata_i;

        if (ack_take || int_dis_cmd_i)     s_d.gate = 1'b0;
        else if (int_en_cmd_i || ien_we_i) s_d.gate = 1'b1;

        s_d.hcf = s_d.evf & s_d.hen;

        if (hold_wake_o)                       s_d.hold = 1'b0;
        else if (hold_req_i && !(|s_q.hcf))    s_d.hold = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hold_o = s_q.hold;
    assign evf_o  = s_q.evf;
    assign hcf_o  = s_q.hcf;
endmodule

// File: rtl/irqh_chk.sv
module irqh_chk #(
    parameter int VECW = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack_i,
    input logic            int_dis_cmd_i,
    input logic            hold_req_i,
    input logic            irq_o,
    input logic [VECW-1:0] vec_o,
    input logic            hold_o,
    input logic            hold_wake_o,
    input logic [7:0]      evf_o,
    input logic [7:0]      hcf_o
);
    AST_ACK_CLOSES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> !irq_o); // R5

    AST_DIS_CLOSES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        int_dis_cmd_i |=> !irq_o); // R6

    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_o != '0 && vec_o[1:0] == 2'b00)); // R4

    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> vec_o == '0); // R4

    AST_HOLD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req_i && !hold_o && (|hcf_o)) |=> !hold_o); // R9

    AST_WAKE_ENDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wake_o |=> !hold_o); // R10

    AST_HCF_WITHIN_EVF: assert property (@(posedge clk) disable iff (!rst_n)
        (hcf_o & ~evf_o) == 8'h00); // R8

    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (evf_o & 8'h68) == 8'h00); // R1
endmodule

bind irq_hold_ctrl irqh_chk #(.VECW(VECW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ack_i         (ack_i),
    .int_dis_cmd_i (int_dis_cmd_i),
    .hold_req_i    (hold_req_i),
    .irq_o         (irq_o),
    .vec_o         (vec_o),
    .hold_o        (hold_o),
    .hold_wake_o   (hold_wake_o),
    .evf_o         (evf_o),
    .hcf_o         (hcf_o)
);

// File: tb/irq_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_hold_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div0 = 0, tmr0 = 0, div1 = 0, tmr1 = 0;
    logic [3:0]  pins = '0;
    logic        ien_we = 0, hen_we = 0, pen_we = 0, clr_we = 0;
    logic [7:0]  ien_wd = '0, hen_wd = '0, clr_m = '0;
    logic [3:0]  pen_wd = '0;
    logic        ack = 0, en_cmd = 0, dis_cmd = 0, hreq = 0;
    logic        irq, hold, wake;
    logic [10:0] vec;
    logic [7:0]  evf, hcf;

    always #4 clk = ~clk;

    irq_hold_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .div0_ovf_i(div0), .tmr0_unf_i(tmr0), .div1_ovf_i(div1), .tmr1_unf_i(tmr1),
        .port_pins_i(pins),
        .ien_we_i(ien_we), .ien_wdata_i(ien_wd),
        .hen_we_i(hen_we), .hen_wdata_i(hen_wd),
        .pen_we_i(pen_we), .pen_wdata_i(pen_wd),
        .evf_clr_we_i(clr_we), .evf_clr_mask_i(clr_m),
        .ack_i(ack), .int_en_cmd_i(en_cmd), .int_dis_cmd_i(dis_cmd),
        .hold_req_i(hreq),
        .irq_o(irq), .vec_o(vec), .hold_o(hold), .hold_wake_o(wake),
        .evf_o(evf), .hcf_o(hcf)
    );

    typedef enum int {K_IRQ, K_VEC, K_EVF, K_HCF, K_HOLD, K_WAKE} kind_t;
    typedef struct {
        kind_t       kind;
        logic [15:0] val;
        string       req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    function automatic logic [15:0] observe(kind_t k);
        case (k)
            K_IRQ:  return {15'd0, irq};
            K_VEC:  return {5'd0, vec};
            K_EVF:  return {8'd0, evf};
            K_HCF:  return {8'd0, hcf};
            K_HOLD: return {15'd0, hold};
            default: return {15'd0, wake};
        endcase
    endfunction

    // Monitor: compares queued expectations 2 ns after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                act = observe(it.kind);
                checks++;
                if (act !== it.val) begin
                    failures++;
                    $display("FAIL %s %s actual=%0h expected=%0h", it.req, it.kind.name(), act, it.val);
                end
            end
        end
    end

    task automatic expect_v(kind_t k, logic [15:0] v, string r);
        item_t it;
        it.kind = k; it.val = v; it.req = r;
        q.push_back(it);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic release_all();
        div0 = 0; tmr0 = 0; div1 = 0; tmr1 = 0;
        ien_we = 0; hen_we = 0; pen_we = 0; clr_we = 0;
        ack = 0; en_cmd = 0; dis_cmd = 0; hreq = 0;
    endtask

    task automatic step();
        cyc();
        release_all();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        expect_v(K_EVF, 0, "R11"); expect_v(K_HCF, 0, "R11");
        expect_v(K_IRQ, 0, "R11"); expect_v(K_HOLD, 0, "R11");
        expect_v(K_VEC, 0, "R11"); expect_v(K_WAKE, 0, "R11");
        rst_n = 1;
        cyc();

        // R3 enable mask write opens gate; R1 timer1 sets bit 7
        ien_we = 1; ien_wd = 8'hFF; step();
        tmr1 = 1; step();
        expect_v(K_EVF, 16'h80, "R1"); expect_v(K_IRQ, 1, "R3"); expect_v(K_VEC, 16'h020, "R4");

        // R4 priority: divider0 beats timer0 and timer1
        div0 = 1; tmr0 = 1; step();
        expect_v(K_EVF, 16'h83, "R1"); expect_v(K_VEC, 16'h004, "R4");

        // R5 acknowledge clears only the winner and closes gate
        ack = 1; step();
        expect_v(K_EVF, 16'h82, "R5"); expect_v(K_IRQ, 0, "R5");
        en_cmd = 1; step();
        expect_v(K_IRQ, 1, "R5"); expect_v(K_VEC, 16'h008, "R5");

        // R6 disable keeps masks; disable beats enable
        dis_cmd = 1; step();
        expect_v(K_IRQ, 0, "R6");
        en_cmd = 1; step();
        expect_v(K_IRQ, 1, "R6");
        dis_cmd = 1; en_cmd = 1; step();
        expect_v(K_IRQ, 0, "R6");
        en_cmd = 1; step();
        expect_v(K_VEC, 16'h008, "R6");

        // R7 masked clear, and set wins over clear
        clr_we = 1; clr_m = 8'h02; step();
        expect_v(K_EVF, 16'h80, "R7"); expect_v(K_VEC, 16'h020, "R7");
        clr_we = 1; clr_m = 8'h80; tmr1 = 1; step();
        expect_v(K_EVF, 16'h80, "R7");
        clr_we = 1; clr_m = 8'h80; step();
        expect_v(K_EVF, 16'h00, "R7"); expect_v(K_IRQ, 0, "R7");

        // R2 port change detector
        pen_we = 1; pen_wd = 4'b0001; step();
        pins = 4'b0010; step();
        expect_v(K_EVF, 16'h00, "R2");
        pins = 4'b0011; step();
        expect_v(K_EVF, 16'h04, "R2"); expect_v(K_IRQ, 1, "R3"); expect_v(K_VEC, 16'h00C, "R4");
        pen_we = 1; pen_wd = 4'b0000; step();
        expect_v(K_IRQ, 0, "R3"); expect_v(K_EVF, 16'h04, "R3");
        clr_we = 1; clr_m = 8'h04; step();
        expect_v(K_EVF, 16'h00, "R7");

        // R8 / R9 hold release conditions
        dis_cmd = 1; step();
        hen_we = 1; hen_wd = 8'h10; step();
        div1 = 1; step();
        expect_v(K_EVF, 16'h10, "R1"); expect_v(K_HCF, 16'h10, "R8"); expect_v(K_IRQ, 0, "R6");
        hreq = 1; step();
        expect_v(K_HOLD, 0, "R9");
        hen_we = 1; hen_wd = 8'h00; step();
        expect_v(K_HCF, 16'h00, "R8"); expect_v(K_EVF, 16'h10, "R8");
        hreq = 1; step();
        expect_v(K_HOLD, 1, "R9"); expect_v(K_WAKE, 0, "R10");
        hen_we = 1; hen_wd = 8'h02; step();
        expect_v(K_HCF, 16'h00, "R8"); expect_v(K_HOLD, 1, "R9");
        tmr0 = 1; step();
        expect_v(K_EVF, 16'h12, "R1"); expect_v(K_HCF, 16'h02, "R8");
        expect_v(K_WAKE, 1, "R10"); expect_v(K_HOLD, 1, "R10");
        step();
        expect_v(K_HOLD, 0, "R10"); expect_v(K_WAKE, 0, "R10");
        clr_we = 1; clr_m = 8'h02; step();
        expect_v(K_HCF, 16'h00, "R8"); expect_v(K_EVF, 16'h10, "R8");

        // R10 pending unmasked interrupt releases hold
        clr_we = 1; clr_m = 8'hFF; step();
        hen_we = 1; hen_wd = 8'h00; step();
        expect_v(K_EVF, 16'h00, "R7");
        hreq = 1; step();
        expect_v(K_HOLD, 1, "R9");
        en_cmd = 1; step();
        expect_v(K_HOLD, 1, "R10"); expect_v(K_WAKE, 0, "R10");
        div0 = 1; step();
        expect_v(K_IRQ, 1, "R10"); expect_v(K_VEC, 16'h004, "R4"); expect_v(K_WAKE, 1, "R10");
        step();
        expect_v(K_HOLD, 0, "R10");

        // R5 new event on the acknowledged bit is kept
        ack = 1; div0 = 1; step();
        expect_v(K_EVF, 16'h01, "R5"); expect_v(K_IRQ, 0, "R5");

        cyc();
        cyc();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule